// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration port of a dual-channel converter. An external host drives a chip select, a serial clock and one bidirectional data line. The block decodes read and write transactions into a small bank of control fields: the channel selection, the operating mode, the clock divider and the duty-cycle stabiliser, the internal reference, and the output code format. All port inputs are sampled by the on-chip clock through synchronisers. The serial clock must therefore run well below the on-chip clock. Each serial-clock half period must last at least five on-chip clock cycles.

After reset the block is in strap mode. In this mode the output-format and stabiliser fields are taken from static strap pins. The first falling edge of chip select switches the block for good into register mode. From then on every field comes from the register bank.

Every transaction begins with a 16-bit header. After the header come one or more data bytes, each sent MSB first. The register address counts down after each byte. During a read, the block drives the data line with the register contents.

Top module: `spi3_ctrl`

## Requirements
- R1: After reset, spi_mode_o is 0 and sdio_oe_o is 0. fmt_o is 2'b01 when pin_fmt_i is 1 and 2'b00 when pin_fmt_i is 0. dcs_o follows pin_dcs_i.
- R2: The first falling edge of cs_i sets spi_mode_o to 1, and it stays 1 until reset. From then on fmt_o and dcs_o come from the registers, and the strap pins have no effect.
- R3: The header is 16 bits, sent MSB first, with sdio_i sampled on rising edges of sclk_i. Bit 15 is the direction (1 = read). Bits 14:13 are the length code. Bits 12:0 are the starting address.
- R4: Length codes 2'b00, 2'b01 and 2'b10 transfer 1, 2 and 3 bytes. Bytes sent after that are ignored. Code 2'b11 keeps transferring until cs_i rises.
- R5: The address decrements by one after each data byte.
- R6: Read data is launched on falling edges of sclk_i, MSB first. sdio_oe_o is 1 only during the data phase of a read. It is 0 during the header and while cs_i is high.
- R7: If cs_i rises in the middle of a byte, that byte is discarded and no register changes.
- R8: The register fields and their defaults are as follows. 0x0003 bits 1:0 hold chan_o (default 2'b11). 0x0005 bits 1:0 hold op_mode_o (default 0). 0x0006 bit 4 holds clkdiv_o and bit 0 holds dcs_o (default 0x01). 0x0008 bit 3 holds iref_en_o and bits 2:0 hold iref_lvl_o (default 0). 0x0011 bits 1:0 hold fmt_o (default 0). Unused bits read as 0.
- R9: Writing 1 to bit 7 of 0x0005 raises swrst_o for exactly one clock. On the next clock every register returns to its default value, and the bit reads back as 0.
- R10: Addresses outside the map read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | On-chip clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdio_i | input | 1 | Serial data line, input side |
| sdio_o | output | 1 | Serial data line, output side |
| sdio_oe_o | output | 1 | Drive enable for the data line |
| pin_fmt_i | input | 1 | Strap: 1 selects two's complement |
| pin_dcs_i | input | 1 | Strap: stabiliser enable |
| spi_mode_o | output | 1 | Register mode active |
| swrst_o | output | 1 | Software reset pulse |
| chan_o | output | 2 | Channel selection |
| op_mode_o | output | 2 | Operating mode |
| clkdiv_o | output | 1 | Clock divide-by-2 enable |
| dcs_o | output | 1 | Duty-cycle stabiliser enable |
| iref_en_o | output | 1 | Internal reference programming enable |
| iref_lvl_o | output | 3 | Internal reference level |
| fmt_o | output | 2 | Output coding (00 offset, 01 two's, 10 Gray, 11 offset) |

## Verification
The bench checks that the length code stops the transfer at the right byte. A design that ignored the code would let the extra byte reach the next lower address and change op_mode_o. Multi-byte reads and writes are checked for address order: a design that counted up would put data into the wrong fields. Chip select is raised in the middle of a byte; a design that committed partial bytes would change chan_o. The software reset and the strap-to-register switch are checked at the output fields. A design that failed to clear the reset bit, or that kept following the straps, would show the wrong field values.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  localparam logic [12:0] A_CHAN = 13'h0003;
  localparam logic [12:0] A_MODE = 13'h0005;
  localparam logic [12:0] A_CLK  = 13'h0006;
  localparam logic [12:0] A_IREF = 13'h0008;
  localparam logic [12:0] A_FMT  = 13'h0011;

  typedef enum logic [1:0] {FR_IDLE, FR_HDR, FR_DATA, FR_DONE} fr_state_e;

  typedef struct packed {
    logic [1:0] chan;
    logic [1:0] op;
    logic       clkdiv;
    logic       dcs;
    logic       iref_en;
    logic [2:0] iref_lvl;
    logic [1:0] fmt;
  } cfg_t;

  localparam cfg_t CFG_DEF = '{chan: 2'b11, op: 2'b00, clkdiv: 1'b0, dcs: 1'b1,
                               iref_en: 1'b0, iref_lvl: 3'd0, fmt: 2'b00};
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[g];
        s2 <= RST_VAL[g];
      end else begin
        s1 <= d_i[g];
        s2 <= s1;
      end
    end
    assign q_o[g] = s2;
  end
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          sclk_s_i,
  input  logic          sdio_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_mode_o,
  output logic          sdio_o,
  output logic          sdio_oe_o
);
  localparam int HW = AW + 3;
  localparam int CW = $clog2(HW);
  localparam int IW = $clog2(DW);

  fr_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [HW-2:0] sr_q;
  logic          rw_q;
  logic [1:0]    len_q, left_q;
  logic [AW-1:0] addr_q;
  logic          sclk_p_q;
  logic          rise, fall;
  logic [HW-1:0] hdr_full;
  logic [IW-1:0] bidx;

  assign rise     = sclk_s_i & ~sclk_p_q;
  assign fall     = ~sclk_s_i & sclk_p_q;
  assign hdr_full = {sr_q, sdio_s_i};
  assign bidx     = IW'(DW - 1) - cnt_q[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= FR_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      rw_q      <= 1'b0;
      len_q     <= '0;
      left_q    <= '0;
      addr_q    <= '0;
      sclk_p_q  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      sdio_o    <= 1'b0;
      sdio_oe_o <= 1'b0;
    end else begin
      sclk_p_q <= sclk_s_i;
      wr_en_o  <= 1'b0;
      if (cs_s_i) begin
        st_q      <= FR_IDLE;
        cnt_q     <= '0;
        sdio_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          FR_IDLE: begin
            st_q  <= FR_HDR;
            cnt_q <= '0;
          end
          FR_HDR: if (rise) begin
            if (cnt_q == CW'(HW - 1)) begin
              rw_q   <= hdr_full[HW-1];
              len_q  <= hdr_full[HW-2:HW-3];
              left_q <= hdr_full[HW-2:HW-3];
              addr_q <= hdr_full[AW-1:0];
              st_q   <= FR_DATA;
              cnt_q  <= '0;
            end else begin
              sr_q  <= {sr_q[HW-3:0], sdio_s_i};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          FR_DATA: begin
            if (fall && rw_q) begin
              sdio_o    <= rd_data_i[bidx];
              sdio_oe_o <= 1'b1;
            end
            if (rise) begin
              sr_q <= {sr_q[HW-3:0], sdio_s_i};
              if (cnt_q == CW'(DW - 1)) begin
                cnt_q <= '0;
                if (!rw_q) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= addr_q;
                  wr_data_o <= {sr_q[DW-2:0], sdio_s_i};
                end
                addr_q <= addr_q - 1'b1;
                left_q <= left_q - 1'b1;
                if (len_q != 2'b11 && left_q == 2'b00) begin
                  st_q      <= FR_DONE;
                  sdio_oe_o <= 1'b0;
                end
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign rd_mode_o = rw_q;
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile
  import spi3_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output cfg_t          cfg_o,
  output logic          swrst_o
);
  cfg_t cfg_q;
  logic swrst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_DEF;
      swrst_q <= 1'b0;
    end else if (swrst_q) begin
      cfg_q   <= CFG_DEF;
      swrst_q <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        AW'(A_CHAN): cfg_q.chan <= wr_data_i[1:0];
        AW'(A_MODE): begin
          cfg_q.op <= wr_data_i[1:0];
          swrst_q  <= wr_data_i[7];
        end
        AW'(A_CLK): begin
          cfg_q.clkdiv <= wr_data_i[4];
          cfg_q.dcs    <= wr_data_i[0];
        end
        AW'(A_IREF): begin
          cfg_q.iref_en  <= wr_data_i[3];
          cfg_q.iref_lvl <= wr_data_i[2:0];
        end
        AW'(A_FMT): cfg_q.fmt <= wr_data_i[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      AW'(A_CHAN): rd_data_o[1:0] = cfg_q.chan;
      AW'(A_MODE): begin
        rd_data_o[1:0] = cfg_q.op;
        rd_data_o[7]   = swrst_q;
      end
      AW'(A_CLK): begin
        rd_data_o[4] = cfg_q.clkdiv;
        rd_data_o[0] = cfg_q.dcs;
      end
      AW'(A_IREF): rd_data_o[3:0] = {cfg_q.iref_en, cfg_q.iref_lvl};
      AW'(A_FMT):  rd_data_o[1:0] = cfg_q.fmt;
      default: ;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign swrst_o = swrst_q;
endmodule

// File: rtl/spi3_ctrl.sv
module spi3_ctrl
  import spi3_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       sclk_i,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe_o,
  input  logic       pin_fmt_i,
  input  logic       pin_dcs_i,
  output logic       spi_mode_o,
  output logic       swrst_o,
  output logic [1:0] chan_o,
  output logic [1:0] op_mode_o,
  output logic       clkdiv_o,
  output logic       dcs_o,
  output logic       iref_en_o,
  output logic [2:0] iref_lvl_o,
  output logic [1:0] fmt_o
);
  logic [2:0]    sync_q;
  logic          cs_s, sclk_s, sdio_s;
  logic          cs_p_q, spi_mode_q;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en, rd_mode;
  cfg_t          cfg;

  spi3_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_i, sclk_i, sdio_i}),
    .q_o    (sync_q)
  );
  assign {cs_s, sclk_s, sdio_s} = sync_q;

  // strap-to-register switch is one-way
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_p_q     <= 1'b1;
      spi_mode_q <= 1'b0;
    end else begin
      cs_p_q     <= cs_s;
      spi_mode_q <= spi_mode_q | (cs_p_q & ~cs_s);
    end
  end

  spi3_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_s),
    .sclk_s_i  (sclk_s),
    .sdio_s_i  (sdio_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_mode_o (rd_mode),
    .sdio_o    (sdio_o),
    .sdio_oe_o (sdio_oe_o)
  );

  spi3_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .cfg_o     (cfg),
    .swrst_o   (swrst_o)
  );

  assign spi_mode_o = spi_mode_q;
  assign chan_o     = cfg.chan;
  assign op_mode_o  = cfg.op;
  assign clkdiv_o   = cfg.clkdiv;
  assign iref_en_o  = cfg.iref_en;
  assign iref_lvl_o = cfg.iref_lvl;
  assign dcs_o      = spi_mode_q ? cfg.dcs : pin_dcs_i;
  assign fmt_o      = spi_mode_q ? cfg.fmt : {1'b0, pin_fmt_i};
endmodule

// File: rtl/spi3_ctrl_chk.sv
module spi3_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_mode_o,
  input logic sdio_oe_o,
  input logic swrst_o,
  input logic clkdiv_o,
  input logic dcs_o,
  input logic cs_s,
  input logic wr_en,
  input logic rd_mode
);
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_mode_o |=> spi_mode_o); // R2
  AST_WR_IN_SPI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> spi_mode_o); // R2
  AST_NO_OE_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_mode_o |-> !sdio_oe_o); // R1
  AST_OE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdio_oe_o); // R6
  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> rd_mode); // R6
  AST_SWRST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |=> !swrst_o); // R9
  AST_SWRST_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |=> (!clkdiv_o && dcs_o)); // R9
endmodule

bind spi3_ctrl spi3_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .spi_mode_o (spi_mode_o),
  .sdio_oe_o  (sdio_oe_o),
  .swrst_o    (swrst_o),
  .clkdiv_o   (clkdiv_o),
  .dcs_o      (dcs_o),
  .cs_s       (cs_s),
  .wr_en      (wr_en),
  .rd_mode    (rd_mode)
);

// File: tb/spi3_ctrl_tb.sv
module spi3_ctrl_tb;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cs = 1'b1, sclk = 1'b0, sdio = 1'b0, pin_fmt = 1'b1, pin_dcs = 1'b0;
  logic sdio_o, sdio_oe, spi_mode, swrst, clkdiv, dcs, iref_en;
  logic [1:0] chan, op_mode, fmt;
  logic [2:0] iref_lvl;

  spi3_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .sdio_i(sdio),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .pin_fmt_i(pin_fmt), .pin_dcs_i(pin_dcs),
    .spi_mode_o(spi_mode), .swrst_o(swrst), .chan_o(chan), .op_mode_o(op_mode),
    .clkdiv_o(clkdiv), .dcs_o(dcs), .iref_en_o(iref_en), .iref_lvl_o(iref_lvl),
    .fmt_o(fmt)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model
  logic [1:0] m_chan, m_op, m_fmt;
  logic       m_clkdiv, m_dcs, m_iren;
  logic [2:0] m_irlvl;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mdl_defaults();
    m_chan = 2'b11; m_op = 0; m_clkdiv = 0; m_dcs = 1; m_iren = 0; m_irlvl = 0; m_fmt = 0;
  endtask

  task automatic mdl_write(logic [12:0] a, logic [7:0] d);
    case (a)
      13'h0003: m_chan = d[1:0];
      13'h0005: if (d[7]) mdl_defaults(); else m_op = d[1:0];
      13'h0006: begin m_clkdiv = d[4]; m_dcs = d[0]; end
      13'h0008: begin m_iren = d[3]; m_irlvl = d[2:0]; end
      13'h0011: m_fmt = d[1:0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] mdl_read(logic [12:0] a);
    case (a)
      13'h0003: return {6'b0, m_chan};
      13'h0005: return {6'b0, m_op};
      13'h0006: return {3'b0, m_clkdiv, 3'b0, m_dcs};
      13'h0008: return {4'b0, m_iren, m_irlvl};
      13'h0011: return {6'b0, m_fmt};
      default:  return 8'h00;
    endcase
  endfunction

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sdio = b;
    wait_h();
    r = sdio_o;
    sclk = 1'b1;
    wait_h();
    sclk = 1'b0;
  endtask

  task automatic header(input logic rw, input logic [1:0] len, input logic [12:0] a);
    logic [15:0] h;
    logic r;
    h = {rw, len, a};
    for (int i = 15; i >= 0; i--) begin
      bit_io(h[i], r);
      if (i == 8) chk("R6 oe low in header", 32'(sdio_oe), 0);
    end
  endtask

  task automatic byte_io(input logic [7:0] w, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) bit_io(w[i], r[i]);
  endtask

  task automatic t_begin();
    cs = 1'b0;
    wait_h();
  endtask

  task automatic t_end();
    wait_h();
    cs = 1'b1;
    wait_h();
  endtask

  task automatic write_n(input logic [1:0] len, input logic [12:0] a, input int n,
                         input logic [31:0] d);
    logic [7:0] tmp;
    int lim;
    t_begin();
    header(1'b0, len, a);
    for (int k = 0; k < n; k++) byte_io(d[31-8*k -: 8], tmp);
    t_end();
    lim = (len == 2'b11) ? n : ((n < int'(len) + 1) ? n : int'(len) + 1);
    for (int k = 0; k < lim; k++) mdl_write(a - 13'(k), d[31-8*k -: 8]);
  endtask

  task automatic read_n(input logic [1:0] len, input logic [12:0] a, input int n,
                        output logic [31:0] r);
    logic [7:0] tmp;
    r = '0;
    t_begin();
    header(1'b1, len, a);
    for (int k = 0; k < n; k++) begin
      byte_io(8'h00, tmp);
      r[31-8*k -: 8] = tmp;
    end
    t_end();
    chk("R6 oe low after cs high", 32'(sdio_oe), 0);
  endtask

  task automatic check_outs(string req);
    chk(req, {chan, op_mode, clkdiv, dcs, iref_en, iref_lvl, fmt},
        {m_chan, m_op, m_clkdiv, m_dcs, m_iren, m_irlvl, m_fmt});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rb;
    logic [12:0] addrs [7];
    logic r;
    addrs = '{13'h0003, 13'h0005, 13'h0006, 13'h0008, 13'h0011, 13'h0007, 13'h1FFF};
    void'($urandom(32'h5eed));
    mdl_defaults();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 strap mode
    chk("R1 spi_mode after reset", 32'(spi_mode), 0);
    chk("R1 oe after reset", 32'(sdio_oe), 0);
    chk("R1 fmt from strap=1", 32'(fmt), 32'h1);
    chk("R1 dcs from strap=0", 32'(dcs), 0);
    pin_fmt = 1'b0; pin_dcs = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 fmt from strap=0", 32'(fmt), 0);
    chk("R1 dcs from strap=1", 32'(dcs), 1);

    // R2 switch on first cs fall
    pin_fmt = 1'b1; pin_dcs = 1'b0;
    t_begin();
    t_end();
    chk("R2 spi_mode set", 32'(spi_mode), 1);
    check_outs("R2 fields from registers, straps ignored");
    chk("R2 fmt not strap", 32'(fmt), 0);

    // R8 defaults readback
    foreach (addrs[i]) begin
      read_n(2'b00, addrs[i], 1, rb);
      chk("R8 default readback", rb[31:24], mdl_read(addrs[i]));
    end

    // R3 single write
    write_n(2'b00, 13'h0006, 1, 32'h11000000);
    check_outs("R3 single write clock reg");
    read_n(2'b00, 13'h0006, 1, rb);
    chk("R8 clock reg readback", rb[31:24], 32'h11);

    // R4 length 00 ignores extra byte (would land on op_mode)
    write_n(2'b00, 13'h0006, 2, 32'h01030000);
    check_outs("R4 length 1 stops");
    chk("R4 op_mode untouched", 32'(op_mode), 0);

    // R5 two-byte write decrements
    write_n(2'b01, 13'h0006, 2, 32'h00020000);
    check_outs("R5 two-byte write 6 then 5");

    // R4 three bytes at 8,7,6
    write_n(2'b10, 13'h0008, 4, 32'h0DFF1003);
    check_outs("R4 length 3 stops after third");

    // R4 continuous 6,5,4,3
    write_n(2'b11, 13'h0006, 4, 32'h0101AA02);
    check_outs("R4 continuous transfer");
    chk("R4 chan via continuous", 32'(chan), 2);

    // R5/R6 multi-byte read
    read_n(2'b01, 13'h0006, 2, rb);
    chk("R5 read addr 6 first", rb[31:24], mdl_read(13'h0006));
    chk("R5 read addr 5 second", rb[23:16], mdl_read(13'h0005));

    // R6 oe high in read data phase
    t_begin();
    header(1'b1, 2'b00, 13'h0003);
    bit_io(1'b0, r);
    chk("R6 first read bit msb", 32'(r), 32'(mdl_read(13'h0003) >> 7));
    chk("R6 oe high in data", 32'(sdio_oe), 1);
    t_end();

    // R7 partial byte abort
    t_begin();
    header(1'b0, 2'b00, 13'h0003);
    for (int i = 0; i < 5; i++) bit_io(1'b1, r);
    t_end();
    check_outs("R7 partial byte discarded");
    read_n(2'b00, 13'h0003, 1, rb);
    chk("R7 chan readback unchanged", rb[31:24], mdl_read(13'h0003));

    // R10 unmapped
    write_n(2'b00, 13'h1FFF, 1, 32'hFF000000);
    read_n(2'b00, 13'h1FFF, 1, rb);
    chk("R10 unmapped reads zero", rb[31:24], 0);
    check_outs("R10 unmapped write ignored");

    // R9 software reset
    write_n(2'b00, 13'h0011, 1, 32'h02000000);
    write_n(2'b00, 13'h0005, 1, 32'h83000000);
    check_outs("R9 all defaults after swrst");
    chk("R9 swrst cleared", 32'(swrst), 0);
    read_n(2'b00, 13'h0005, 1, rb);
    chk("R9 mode reads zero", rb[31:24], 0);

    // random write/read pairs
    for (int it = 0; it < 50; it++) begin
      logic [12:0] a;
      logic [7:0] d;
      a = addrs[$urandom_range(6, 0)];
      d = 8'($urandom);
      if (a == 13'h0005 && ($urandom_range(7, 0) != 0)) d[7] = 1'b0;
      write_n(2'b00, a, 1, {d, 24'h0});
      check_outs("R8 random write fields");
      read_n(2'b00, a, 1, rb);
      chk("R8 random readback", rb[31:24], mdl_read(a));
    end

    chk("R2 spi_mode held", 32'(spi_mode), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule